// File: doc/BRIEF.md
# Sequenced Credit Generator for a Pull-Mode Receive Queue

This block sits on the receive side of a network interface, next to a single receive queue. Data producers may only send words into the queue against credits they have been given. The block hands out free queue slots as credits. It serves producers one after another, following a small program table. Each table entry names a producer, the number of credits to give in one grant, and the length in words of the data block expected from that producer.

The block keeps track of three quantities: the free slots in the queue, the credits still outstanding to the current producer, and the progress through the current data block. A new credit message goes out only when the previous grant has been fully consumed. When the block length of an entry has arrived, the block raises a one-cycle completion pulse and moves to the next entry. After the programmed last entry it wraps back to entry 0.

Several sequential flows can be merged into one queue by listing their producers one after another in the table. Simultaneous flows use one instance of this block per queue.

Credit messages leave on a valid/ready channel. Once `crd_valid` is raised, the producer ID and count stay stable until `crd_ready` is sampled high. The credit is counted as spent only on that handshake. Arriving words and dequeues are single-cycle strobes with no back-pressure. The pull scheme guarantees that an arriving word always has a slot.

Top module: `credit_sequencer`

## Requirements
- R1: While reset is asserted and right after it, `crd_valid` and `blk_done` are 0, and `free_slots` equals the queue depth (16 by default).
- R2: A credit message is offered only when all of the following hold: `run` is high, no credit message is pending, nothing is outstanding to the current producer, the current block has words not yet granted, and `free_slots` is at least the grant count.
- R3: The grant count is the smaller of the entry's credits-per-grant value and the number of block words not yet granted. `crd_src` carries the entry's producer ID.
- R4: While `crd_valid` is high and `crd_ready` is low, `crd_valid`, `crd_src` and `crd_count` hold. Nothing is counted until the handshake.
- R5: `free_slots` drops by the grant count on a credit handshake and rises by one for each cycle with `deq` high. Both apply in the same cycle, and the value never exceeds the depth.
- R6: A word strobe (`wr_en`) is ignored when its `wr_src` differs from the current entry's producer, or when nothing is outstanding to that producer. Word arrivals never change `free_slots`.
- R7: When the last word of the current block arrives, `blk_done` is high for exactly one cycle (the cycle after that word), `blk_idx` gives the finished entry's index, and the next entry is served.
- R8: After the entry at `last_idx` completes, service wraps to entry 0.
- R9: With `run` low, no new credit message is offered. A pending message still completes its handshake.
- R10: An entry whose credits-per-grant value is 0 never offers a credit message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Permits new credit offers |
| prog_we | input | 1 | Program-table write strobe |
| prog_idx | input | IDX_W | Table entry to write |
| prog_src | input | SRC_W | Producer ID for the entry |
| prog_grant | input | CNT_W | Credits per grant for the entry |
| prog_blen | input | CNT_W | Block length in words for the entry (at least 1) |
| last_idx | input | IDX_W | Last table index before wrapping to 0 |
| wr_en | input | 1 | A word was written into the queue |
| wr_src | input | SRC_W | Producer that sent that word |
| deq | input | 1 | A word was removed from the queue |
| crd_valid | output | 1 | Credit message valid |
| crd_ready | input | 1 | Credit message accepted |
| crd_src | output | SRC_W | Producer the credits are for |
| crd_count | output | CNT_W | Number of credits granted |
| free_slots | output | SPACE_W | Unreserved slots in the queue |
| blk_done | output | 1 | One-cycle pulse: a block finished |
| blk_idx | output | IDX_W | Table index of the finished block |

## Verification
The bench walks several single-entry programs whose block length is not a multiple of the grant size. A design that did not clip the final grant would over-reserve space, and the credit-count checks would catch it.

It fills the queue exactly without draining it, then drains one slot short of a full grant. A design that compared free space with `>` or ignored space entirely would offer a credit too early or never.

It holds `crd_ready` low to confirm that the message is frozen and that space is not taken before the handshake. It injects a word from a foreign producer, which a careless design would count toward the block and so finish one word early.

A three-entry program run through a wrap shows whether the pointer advances and returns to entry 0. A zero grant size and a low `run` must both leave the channel silent.

// File: rtl/credit_sequencer_pkg.sv
`timescale 1ns/1ps
package credit_sequencer_pkg;
  localparam int SRC_W = 4;
  localparam int CNT_W = 8;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [CNT_W-1:0] grant;
    logic [CNT_W-1:0] blen;
  } prog_entry_t;
endpackage

// File: rtl/credit_sequencer_table.sv
`timescale 1ns/1ps
module credit_sequencer_table
  import credit_sequencer_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int IDX_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  prog_entry_t      wdata,
  input  logic [IDX_W-1:0] ridx,
  output prog_entry_t      rdata
);
  prog_entry_t mem [NUM_ENTRIES];

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (we && widx == IDX_W'(i))
        mem[i] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/credit_sequencer_space.sv
`timescale 1ns/1ps
module credit_sequencer_space #(
  parameter int DEPTH   = 16,
  parameter int SPACE_W = 5,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [CNT_W-1:0]   take_cnt,
  input  logic               give,
  output logic [SPACE_W-1:0] free
);
  localparam int CW = ((SPACE_W > CNT_W) ? SPACE_W : CNT_W) + 1;

  logic [SPACE_W-1:0] free_q;
  logic [CW-1:0]      sum;

  always_comb begin
    sum = CW'(free_q) + CW'(give) - (take ? CW'(take_cnt) : '0);
    if (sum > CW'(DEPTH))
      sum = CW'(DEPTH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      free_q <= SPACE_W'(DEPTH);
    else
      free_q <= SPACE_W'(sum);
  end

  assign free = free_q;
endmodule

// File: rtl/credit_sequencer_engine.sv
`timescale 1ns/1ps
module credit_sequencer_engine
  import credit_sequencer_pkg::*;
#(
  parameter int IDX_W   = 2,
  parameter int SPACE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  prog_entry_t        entry,
  input  logic [IDX_W-1:0]   last_idx,
  input  logic               wr_en,
  input  logic [SRC_W-1:0]   wr_src,
  input  logic [SPACE_W-1:0] free,
  input  logic               crd_ready,
  output logic               crd_valid,
  output logic [SRC_W-1:0]   crd_src,
  output logic [CNT_W-1:0]   crd_count,
  output logic               hs,
  output logic [IDX_W-1:0]   ptr,
  output logic               blk_done,
  output logic [IDX_W-1:0]   blk_idx
);
  localparam int CW = ((SPACE_W > CNT_W) ? SPACE_W : CNT_W) + 1;

  logic [IDX_W-1:0] ptr_q, done_idx_q;
  logic [CNT_W-1:0] issued_q, received_q, owed_q, cnt_q;
  logic [SRC_W-1:0] src_q;
  logic             valid_q, done_q;

  logic [CNT_W-1:0] remain, want;
  logic             fits, offer, accept, finish;

  always_comb begin
    remain = entry.blen - issued_q;
    want   = (entry.grant < remain) ? entry.grant : remain;
    fits   = CW'(free) >= CW'(want);
    offer  = run && !valid_q && (owed_q == '0) && (remain != '0)
             && (want != '0) && fits;
    hs     = valid_q && crd_ready;
    accept = wr_en && (wr_src == entry.src) && (owed_q != '0);
    finish = accept && ((received_q + CNT_W'(1)) == entry.blen);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      issued_q   <= '0;
      received_q <= '0;
      owed_q     <= '0;
      done_q     <= 1'b0;
      done_idx_q <= '0;
    end else begin
      done_q <= finish;
      if (finish) begin
        issued_q   <= '0;
        received_q <= '0;
        owed_q     <= '0;
        done_idx_q <= ptr_q;
        ptr_q      <= (ptr_q == last_idx) ? '0 : ptr_q + IDX_W'(1);
      end else begin
        if (hs)
          issued_q <= issued_q + cnt_q;
        received_q <= received_q + CNT_W'(accept);
        owed_q     <= owed_q + (hs ? cnt_q : '0) - CNT_W'(accept);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      src_q   <= '0;
      cnt_q   <= '0;
    end else if (offer) begin
      valid_q <= 1'b1;
      src_q   <= entry.src;
      cnt_q   <= want;
    end else if (hs) begin
      valid_q <= 1'b0;
    end
  end

  assign crd_valid = valid_q;
  assign crd_src   = src_q;
  assign crd_count = cnt_q;
  assign ptr       = ptr_q;
  assign blk_done  = done_q;
  assign blk_idx   = done_idx_q;
endmodule

// File: rtl/credit_sequencer.sv
`timescale 1ns/1ps
module credit_sequencer
  import credit_sequencer_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int DEPTH       = 16,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int SPACE_W    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               prog_we,
  input  logic [IDX_W-1:0]   prog_idx,
  input  logic [SRC_W-1:0]   prog_src,
  input  logic [CNT_W-1:0]   prog_grant,
  input  logic [CNT_W-1:0]   prog_blen,
  input  logic [IDX_W-1:0]   last_idx,
  input  logic               wr_en,
  input  logic [SRC_W-1:0]   wr_src,
  input  logic               deq,
  output logic               crd_valid,
  input  logic               crd_ready,
  output logic [SRC_W-1:0]   crd_src,
  output logic [CNT_W-1:0]   crd_count,
  output logic [SPACE_W-1:0] free_slots,
  output logic               blk_done,
  output logic [IDX_W-1:0]   blk_idx
);
  prog_entry_t      wentry, cur;
  logic [IDX_W-1:0] ptr;
  logic             hs;

  assign wentry = '{src: prog_src, grant: prog_grant, blen: prog_blen};

  credit_sequencer_table #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .we(prog_we), .widx(prog_idx),
    .wdata(wentry), .ridx(ptr), .rdata(cur)
  );

  credit_sequencer_space #(.DEPTH(DEPTH), .SPACE_W(SPACE_W), .CNT_W(CNT_W)) u_space (
    .clk(clk), .rst_n(rst_n), .take(hs), .take_cnt(crd_count),
    .give(deq), .free(free_slots)
  );

  credit_sequencer_engine #(.IDX_W(IDX_W), .SPACE_W(SPACE_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .run(run), .entry(cur), .last_idx(last_idx),
    .wr_en(wr_en), .wr_src(wr_src), .free(free_slots), .crd_ready(crd_ready),
    .crd_valid(crd_valid), .crd_src(crd_src), .crd_count(crd_count),
    .hs(hs), .ptr(ptr), .blk_done(blk_done), .blk_idx(blk_idx)
  );
endmodule

// File: rtl/credit_sequencer_chk.sv
`timescale 1ns/1ps
module credit_sequencer_chk #(
  parameter int DEPTH   = 16,
  parameter int SPACE_W = 5,
  parameter int SRC_W   = 4,
  parameter int CNT_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic               deq,
  input logic               crd_valid,
  input logic               crd_ready,
  input logic [SRC_W-1:0]   crd_src,
  input logic [CNT_W-1:0]   crd_count,
  input logic [SPACE_W-1:0] free_slots,
  input logic               blk_done
);
  localparam int CW = ((SPACE_W > CNT_W) ? SPACE_W : CNT_W) + 1;

  a_r4_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (crd_valid && !crd_ready) |=> (crd_valid && $stable(crd_src) && $stable(crd_count)));

  a_r2_space_fits: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crd_valid) |-> (CW'($past(free_slots)) >= CW'(crd_count)));

  a_r9_run_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crd_valid) |-> $past(run));

  a_r10_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    crd_valid |-> (crd_count != '0));

  a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(free_slots) <= CW'(DEPTH));

  a_r5_take: assert property (@(posedge clk) disable iff (!rst_n)
    (crd_valid && crd_ready && !deq) |=>
      (CW'(free_slots) + CW'($past(crd_count)) == CW'($past(free_slots))));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);
endmodule

bind credit_sequencer credit_sequencer_chk #(
  .DEPTH(DEPTH), .SPACE_W(SPACE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .deq(deq),
  .crd_valid(crd_valid), .crd_ready(crd_ready), .crd_src(crd_src),
  .crd_count(crd_count), .free_slots(free_slots), .blk_done(blk_done)
);

// File: tb/credit_sequencer_tb.sv
`timescale 1ns/1ps
module credit_sequencer_tb;
  localparam int DEPTH = 16;
  // rows: {src, grant, blen}, 8 bits each
  localparam logic [23:0] VEC [4] = '{
    {8'd3, 8'd4,  8'd10},
    {8'd1, 8'd16, 8'd16},
    {8'd2, 8'd5,  8'd5},
    {8'd7, 8'd3,  8'd1}
  };

  logic       clk = 1'b0;
  logic       rst_n, run, prog_we, wr_en, deq, crd_ready;
  logic [1:0] prog_idx, last_idx, blk_idx;
  logic [3:0] prog_src, wr_src, crd_src;
  logic [7:0] prog_grant, prog_blen, crd_count;
  logic [4:0] free_slots;
  logic       crd_valid, blk_done;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  credit_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .prog_we(prog_we), .prog_idx(prog_idx),
    .prog_src(prog_src), .prog_grant(prog_grant), .prog_blen(prog_blen),
    .last_idx(last_idx), .wr_en(wr_en), .wr_src(wr_src), .deq(deq),
    .crd_valid(crd_valid), .crd_ready(crd_ready), .crd_src(crd_src),
    .crd_count(crd_count), .free_slots(free_slots), .blk_done(blk_done),
    .blk_idx(blk_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic prog(input int idx, input int src, input int g, input int b);
    @(negedge clk);
    prog_we = 1'b1; prog_idx = 2'(idx); prog_src = 4'(src);
    prog_grant = 8'(g); prog_blen = 8'(b);
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic wait_credit(output bit got, output int cnt, output int src);
    got = 1'b0; cnt = 0; src = 0;
    for (int i = 0; i < 30 && !got; i++) begin
      @(negedge clk);
      if (crd_valid) begin
        got = 1'b1; cnt = int'(crd_count); src = int'(crd_src);
      end
    end
  endtask

  task automatic send_words(input int n, input int src, input bit d,
                            output bit dn, output int didx);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_src = 4'(src); deq = d;
    end
    @(negedge clk);
    dn = blk_done; didx = int'(blk_idx);
    wr_en = 1'b0; deq = 1'b0;
  endtask

  task automatic idle_no_credit(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!crd_valid, tag, int'(crd_valid), 0);
    end
  endtask

  task automatic run_block(input int src, input int g, input int b,
                           input int idx, input bit stop);
    int issued = 0;
    bit got, dn;
    int cnt, s, didx, exp;
    while (issued < b) begin
      wait_credit(got, cnt, s);
      chk(got, "R2 credit offered", int'(got), 1);
      if (!got) return;
      exp = (g < b - issued) ? g : b - issued;
      chk(cnt == exp, "R3 grant count", cnt, exp);
      chk(s == src, "R3 credit source", s, src);
      issued += cnt;
      if (issued >= b && stop) run = 1'b0;
      send_words(cnt, src, 1'b1, dn, didx);
      chk(dn == (issued >= b), "R7 done pulse", int'(dn), int'(issued >= b));
      if (issued >= b) chk(didx == idx, "R8 done index", didx, idx);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    bit got, dn;
    int cnt, s, didx;
    rst_n = 1'b0; run = 1'b0; prog_we = 1'b0; prog_idx = '0; prog_src = '0;
    prog_grant = '0; prog_blen = '0; last_idx = '0; wr_en = 1'b0;
    wr_src = '0; deq = 1'b0; crd_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!crd_valid, "R1 reset valid", int'(crd_valid), 0);
    chk(!blk_done, "R1 reset done", int'(blk_done), 0);
    chk(free_slots == 5'(DEPTH), "R1 reset space", int'(free_slots), DEPTH);
    rst_n = 1'b1;
    @(negedge clk);
    chk(free_slots == 5'(DEPTH), "R1 space after reset", int'(free_slots), DEPTH);

    // vector walk: single-entry programs
    foreach (VEC[k]) begin
      prog(0, int'(VEC[k][23:16]), int'(VEC[k][15:8]), int'(VEC[k][7:0]));
      run = 1'b1;
      run_block(int'(VEC[k][23:16]), int'(VEC[k][15:8]), int'(VEC[k][7:0]), 0, 1'b1);
      chk(free_slots == 5'(DEPTH), "R5 space restored", int'(free_slots), DEPTH);
    end

    // R4 back-pressure, R6 foreign and extra words
    crd_ready = 1'b0;
    prog(0, 5, 4, 4);
    run = 1'b1;
    wait_credit(got, cnt, s);
    chk(got && cnt == 4, "R4 offer present", cnt, 4);
    run = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(crd_valid && crd_count == 8'd4 && crd_src == 4'd5, "R4 held offer",
          int'(crd_count), 4);
      chk(free_slots == 5'(DEPTH), "R4 no early take", int'(free_slots), DEPTH);
    end
    crd_ready = 1'b1;
    @(negedge clk);
    chk(!crd_valid, "R4 offer cleared", int'(crd_valid), 0);
    chk(free_slots == 5'(DEPTH - 4), "R5 take on handshake", int'(free_slots), DEPTH - 4);
    send_words(1, 6, 1'b0, dn, didx);
    chk(!dn, "R6 foreign word ignored", int'(dn), 0);
    send_words(3, 5, 1'b0, dn, didx);
    chk(!dn, "R6 block not early", int'(dn), 0);
    chk(free_slots == 5'(DEPTH - 4), "R6 arrivals keep space", int'(free_slots), DEPTH - 4);
    send_words(1, 5, 1'b0, dn, didx);
    chk(dn && didx == 0, "R7 done after last word", int'(dn), 1);
    send_words(1, 5, 1'b0, dn, didx);
    chk(!dn, "R6 unowed word ignored", int'(dn), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); deq = 1'b1;
    end
    @(negedge clk); deq = 1'b0;
    chk(free_slots == 5'(DEPTH), "R5 dequeues return space", int'(free_slots), DEPTH);

    // R2 exact-fit space limit
    prog(0, 1, 16, 32);
    run = 1'b1;
    wait_credit(got, cnt, s);
    chk(got && cnt == 16, "R3 full grant", cnt, 16);
    send_words(16, 1, 1'b0, dn, didx);
    chk(free_slots == 5'd0, "R5 queue full", int'(free_slots), 0);
    idle_no_credit(5, "R2 no credit when full");
    for (int i = 0; i < 15; i++) begin
      @(negedge clk); deq = 1'b1;
      chk(!crd_valid, "R2 no credit below grant", int'(crd_valid), 0);
    end
    @(negedge clk); deq = 1'b0;
    chk(!crd_valid, "R2 no credit at 15", int'(crd_valid), 0);
    chk(free_slots == 5'd15, "R5 partial drain", int'(free_slots), 15);
    @(negedge clk); deq = 1'b1;
    @(negedge clk); deq = 1'b0;
    wait_credit(got, cnt, s);
    chk(got && cnt == 16, "R2 credit at exact fit", cnt, 16);
    run = 1'b0;
    send_words(16, 1, 1'b1, dn, didx);
    chk(dn, "R7 done after second grant", int'(dn), 1);

    // R10 zero grant size
    prog(0, 2, 0, 4);
    run = 1'b1;
    idle_no_credit(6, "R10 zero grant silent");
    prog(0, 2, 2, 4);
    run_block(2, 2, 4, 0, 1'b1);

    // R9 run gating
    prog(0, 3, 2, 2);
    idle_no_credit(5, "R9 run low silent");
    run = 1'b1;
    run_block(3, 2, 2, 0, 1'b1);

    // R7/R8 sequence and wrap
    prog(0, 2, 2, 2);
    prog(1, 3, 1, 2);
    prog(2, 4, 3, 3);
    last_idx = 2'd2;
    run = 1'b1;
    run_block(2, 2, 2, 0, 1'b0);
    run_block(3, 1, 2, 1, 1'b0);
    run_block(4, 3, 3, 2, 1'b0);
    run_block(2, 2, 2, 0, 1'b1); // R8 wrap back to entry 0
    idle_no_credit(3, "R9 stopped after wrap");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule